// File: doc/BRIEF.md
# Legacy Paravirtual Device Header Register Slave

This block is the register front end of a legacy paravirtual I/O device that sits behind a single memory window. A host issues single reads and writes with an offset, a size code and write data. Offsets below the device-specific boundary select one of eight header registers:

- the feature word offered by the device and the feature word accepted by the driver;
- the ring address and ring size of the currently selected queue, and the queue selector;
- the queue notification register, the device status byte and the interrupt status byte.

Offsets from the boundary up to the end of the configuration area are passed to a configuration port, with the boundary subtracted from the offset.

The block also delivers interrupts. A kick from the device logic sets a pending flag, and the interrupt line follows that flag. A read of the interrupt status byte reports the flag and then clears it. A notification write produces a one-cycle service pulse that carries the queue index to the device logic.

Every access gets exactly one response, one cycle after the request. The response carries read data, an error flag for illegal accesses and a warning flag for writes that are ignored.

Top module: `vio_hdr_port`

## Requirements
- R1: After reset, `irq`, `rspValid` and `notifyValid` are low. Every header register reads 0, except the device feature word, which reads `DEV_FEATURES`, and the ring size.
- R2: Each header register has a fixed offset and a fixed size code. `reqSize` encodes 0 as one byte, 1 as two bytes and 2 as four bytes. The map is:
  - 0x00: device features, 4 bytes
  - 0x04: driver features, 4 bytes
  - 0x08: ring address, 4 bytes
  - 0x0C: ring size, 2 bytes
  - 0x0E: queue select, 2 bytes
  - 0x10: notify, 2 bytes
  - 0x12: status, 1 byte
  - 0x13: interrupt status, 1 byte
  
  A read of 0x00 returns `DEV_FEATURES`.
- R3: The driver feature word (0x04) and the queue selector (0x0E) store what is written and read it back.
- R4: Each of the `NUM_QUEUES` queues has its own ring address. Reads at 0x08 and 0x0C refer to the queue named by the selector. The ring size reads `QUEUE_DEPTH`. When the selector is `NUM_QUEUES` or above, both registers read 0 and a ring address write is dropped.
- R5: A notify write stores the 16-bit index, which then reads back from 0x10. In the response cycle, `notifyValid` is high for exactly one cycle and `notifyIdx` carries the index.
- R6: A `kick` sets the pending flag. `irq` is high from the next cycle on.
- R7: A read of 0x13 returns the pending flag in bit 0, with all other bits 0, and clears the flag and `irq`. If a kick arrives in the same cycle, the kick wins and `irq` stays high.
- R8: Writes to 0x00 and 0x13 change nothing and respond with `rspWarn` set.
- R9: The following accesses respond with `rspErr` set, data 0 and no state change:
  - a write to 0x0C;
  - a size code that does not match the register's size;
  - an unmapped header offset;
  - an offset at or above the window size;
  - an offset inside the window but past the configuration area.
- R10: An offset from 0x14 up to 0x14+`CFG_SIZE`-1 raises `cfgValid` in the request cycle. It presents the offset minus 0x14, together with the size code, the write data and `cfgWrite`. A read response returns `cfgRdData` as sampled in that cycle, and the header registers are left untouched.
- R11: `winSize` equals 0x14+`CFG_SIZE` rounded up to the next power of two.
- R12: The status byte (0x12) stores writes. Writing 0 resets the device: it clears the status byte, the driver feature word, the queue selector and the pending flag, and a kick in the same cycle still wins for the flag.
- R13: `rspValid` rises exactly one cycle after each request and at no other time. Write responses carry data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Offset within the window |
| reqSize | input | 2 | Size code: 0 byte, 1 half, 2 word |
| reqWdata | input | 32 | Write data, right-aligned |
| rspValid | output | 1 | Response strobe |
| rspData | output | 32 | Read data |
| rspErr | output | 1 | Access was illegal |
| rspWarn | output | 1 | Write was ignored |
| cfgValid | output | 1 | Device-specific access, same cycle as request |
| cfgWrite | output | 1 | Device-specific access is a write |
| cfgOffset | output | ADDR_W | Rebased offset into configuration area |
| cfgSize | output | 2 | Size code of the forwarded access |
| cfgWdata | output | 32 | Forwarded write data |
| cfgRdData | input | 32 | Configuration read data, sampled in request cycle |
| kick | input | 1 | Device requests an interrupt |
| irq | output | 1 | Interrupt line |
| notifyValid | output | 1 | One-cycle queue service pulse |
| notifyIdx | output | 16 | Queue index for the service pulse |
| winSize | output | 32 | Window size advertised for the base address |

## Verification
The bench builds the block with three queues, a ring depth of 128 and a 13-byte configuration area. With these values the window rounds up from 33 to 64 bytes. Offset 0x21 then falls inside the window but past the configuration area, and offset 0x40 lies just outside the window, so both range checks can be reached. Three queues let a selector of 1 and 2 pick different stored ring addresses, while a selector of 5 reaches the unimplemented-queue case. The same-cycle collision of a kick with a clearing read, or with a status reset, is driven on purpose.

// File: rtl/vio_hdr_pkg.sv
package vio_hdr_pkg;

  // first offset of the device-specific configuration area
  localparam int unsigned HDR_END = 32'h14;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [3:0] {
    RD_NONE, RD_DEVF, RD_GUEST, RD_QADDR, RD_QSIZE,
    RD_QSEL, RD_NOTIFY, RD_STATUS, RD_ISR, RD_CFG
  } rdSel_e;

  // strobes from decode control to register datapath
  typedef struct packed {
    logic   acc;
    logic   wrGuest;
    logic   wrQaddr;
    logic   wrQsel;
    logic   wrNotify;
    logic   wrStatus;
    logic   rdIsr;
    logic   isErr;
    logic   isWarn;
    rdSel_e sel;
  } hdrCmd_t;

  function automatic int unsigned nextPow2(int unsigned v);
    int unsigned p;
    p = 1;
    while (p < v) p = p << 1;
    return p;
  endfunction

endpackage

// File: rtl/vio_hdr_ctrl.sv
module vio_hdr_ctrl
  import vio_hdr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned CFG_SIZE = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  output hdrCmd_t           cmd,
  output logic              cfgValid,
  output logic              cfgWrite,
  output logic [ADDR_W-1:0] cfgOffset
);

  localparam int unsigned WIN = nextPow2(HDR_END + CFG_SIZE);

  logic [31:0] wide;
  logic [31:0] cfgRel;
  logic        hit;
  logic [1:0]  expSz;
  rdSel_e      regSel;

  assign wide   = 32'(reqAddr);
  assign cfgRel = wide - HDR_END;

  // header offset map
  always_comb begin
    hit    = 1'b1;
    expSz  = SZ_WORD;
    regSel = RD_NONE;
    case (wide)
      32'h00:  begin expSz = SZ_WORD; regSel = RD_DEVF;   end
      32'h04:  begin expSz = SZ_WORD; regSel = RD_GUEST;  end
      32'h08:  begin expSz = SZ_WORD; regSel = RD_QADDR;  end
      32'h0C:  begin expSz = SZ_HALF; regSel = RD_QSIZE;  end
      32'h0E:  begin expSz = SZ_HALF; regSel = RD_QSEL;   end
      32'h10:  begin expSz = SZ_HALF; regSel = RD_NOTIFY; end
      32'h12:  begin expSz = SZ_BYTE; regSel = RD_STATUS; end
      32'h13:  begin expSz = SZ_BYTE; regSel = RD_ISR;    end
      default: hit = 1'b0;
    endcase
  end

  always_comb begin
    cmd       = '0;
    cmd.sel   = RD_NONE;
    cfgValid  = 1'b0;
    cfgOffset = '0;
    if (reqValid) begin
      cmd.acc = 1'b1;
      if (wide >= WIN) begin
        cmd.isErr = 1'b1;
      end else if (wide >= HDR_END) begin
        if (cfgRel < CFG_SIZE) begin
          cfgValid  = 1'b1;
          cfgOffset = cfgRel[ADDR_W-1:0];
          if (!reqWrite) cmd.sel = RD_CFG;
        end else begin
          cmd.isErr = 1'b1;
        end
      end else if (!hit || reqSize != expSz) begin
        cmd.isErr = 1'b1;
      end else if (!reqWrite) begin
        cmd.sel   = regSel;
        cmd.rdIsr = (regSel == RD_ISR);
      end else begin
        case (regSel)
          RD_DEVF, RD_ISR: cmd.isWarn   = 1'b1;
          RD_QSIZE:        cmd.isErr    = 1'b1;
          RD_GUEST:        cmd.wrGuest  = 1'b1;
          RD_QADDR:        cmd.wrQaddr  = 1'b1;
          RD_QSEL:         cmd.wrQsel   = 1'b1;
          RD_NOTIFY:       cmd.wrNotify = 1'b1;
          RD_STATUS:       cmd.wrStatus = 1'b1;
          default:         cmd.isErr    = 1'b1;
        endcase
      end
    end
  end

  assign cfgWrite = cfgValid & reqWrite;

  // R10: a forwarded offset always lies inside the configuration area
  p_cfg_in_range_r10: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |-> (32'(cfgOffset) < CFG_SIZE && 32'(reqAddr) >= HDR_END));

  // R9: a forwarded access never also reports an error
  p_cfg_not_err_r9: assert property (@(posedge clk) disable iff (!rstN)
    cfgValid |-> !cmd.isErr);

endmodule

// File: rtl/vio_hdr_dp.sv
module vio_hdr_dp
  import vio_hdr_pkg::*;
#(
  parameter int unsigned NUM_QUEUES   = 2,
  parameter int unsigned QUEUE_DEPTH  = 256,
  parameter logic [31:0] DEV_FEATURES = 32'h0000_0001
) (
  input  logic        clk,
  input  logic        rstN,
  input  hdrCmd_t     cmd,
  input  logic [31:0] wdata,
  input  logic [31:0] cfgRdData,
  input  logic        kick,
  output logic        rspValid,
  output logic [31:0] rspData,
  output logic        rspErr,
  output logic        rspWarn,
  output logic        notifyValid,
  output logic [15:0] notifyIdx,
  output logic        irq
);

  logic [31:0] guestFeat;
  logic [15:0] qSel;
  logic [15:0] notifyReg;
  logic [7:0]  devStatus;
  logic        pending;
  logic [31:0] qAddr [NUM_QUEUES];
  logic [31:0] curQaddr;
  logic [31:0] rdMux;
  logic        qSelOk;
  logic        devReset;

  assign qSelOk   = 32'(qSel) < NUM_QUEUES;
  assign devReset = cmd.wrStatus && (wdata[7:0] == 8'h00);

  // one ring address per queue
  for (genvar q = 0; q < NUM_QUEUES; q++) begin : gQueue
    always_ff @(posedge clk) begin
      if (!rstN)
        qAddr[q] <= '0;
      else if (cmd.wrQaddr && qSel == 16'(q))
        qAddr[q] <= wdata;
    end
  end

  always_comb begin
    curQaddr = '0;
    for (int q = 0; q < NUM_QUEUES; q++)
      if (qSel == 16'(q)) curQaddr = qAddr[q];
  end

  always_comb begin
    case (cmd.sel)
      RD_DEVF:   rdMux = DEV_FEATURES;
      RD_GUEST:  rdMux = guestFeat;
      RD_QADDR:  rdMux = qSelOk ? curQaddr : 32'h0;
      RD_QSIZE:  rdMux = qSelOk ? {16'h0, 16'(QUEUE_DEPTH)} : 32'h0;
      RD_QSEL:   rdMux = {16'h0, qSel};
      RD_NOTIFY: rdMux = {16'h0, notifyReg};
      RD_STATUS: rdMux = {24'h0, devStatus};
      RD_ISR:    rdMux = {31'h0, pending};
      RD_CFG:    rdMux = cfgRdData;
      default:   rdMux = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      guestFeat <= '0;
      qSel      <= '0;
      notifyReg <= '0;
      devStatus <= '0;
      pending   <= 1'b0;
    end else begin
      if (devReset) begin
        guestFeat <= '0;
        qSel      <= '0;
      end else begin
        if (cmd.wrGuest) guestFeat <= wdata;
        if (cmd.wrQsel)  qSel      <= wdata[15:0];
      end
      if (cmd.wrNotify) notifyReg <= wdata[15:0];
      if (cmd.wrStatus) devStatus <= wdata[7:0];
      if (kick)
        pending <= 1'b1;
      else if (cmd.rdIsr || devReset)
        pending <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid    <= 1'b0;
      rspData     <= '0;
      rspErr      <= 1'b0;
      rspWarn     <= 1'b0;
      notifyValid <= 1'b0;
      notifyIdx   <= '0;
    end else begin
      rspValid    <= cmd.acc;
      rspData     <= rdMux;
      rspErr      <= cmd.isErr;
      rspWarn     <= cmd.isWarn;
      notifyValid <= cmd.wrNotify;
      notifyIdx   <= cmd.wrNotify ? wdata[15:0] : notifyIdx;
    end
  end

  assign irq = pending;

  // R6: a kick always shows on the interrupt line next cycle
  p_kick_raises_irq_r6: assert property (@(posedge clk) disable iff (!rstN)
    kick |=> irq);

  // R7: a status read without a concurrent kick drops the line
  p_isr_read_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.rdIsr && !kick) |=> !irq);

  // R12: device reset drops a pending interrupt
  p_reset_drops_irq_r12: assert property (@(posedge clk) disable iff (!rstN)
    (devReset && !kick) |=> !irq);

  // R5: a service pulse only rides on a good response
  p_notify_on_rsp_r5: assert property (@(posedge clk) disable iff (!rstN)
    notifyValid |-> (rspValid && !rspErr && !rspWarn));

  // R9: error and warning never coincide
  p_err_warn_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(rspErr && rspWarn));

endmodule

// File: rtl/vio_hdr_port.sv
module vio_hdr_port
  import vio_hdr_pkg::*;
#(
  parameter int unsigned ADDR_W       = 8,
  parameter int unsigned NUM_QUEUES   = 2,
  parameter int unsigned QUEUE_DEPTH  = 256,
  parameter int unsigned CFG_SIZE     = 8,
  parameter logic [31:0] DEV_FEATURES = 32'h0000_0001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [31:0]       reqWdata,
  output logic              rspValid,
  output logic [31:0]       rspData,
  output logic              rspErr,
  output logic              rspWarn,
  output logic              cfgValid,
  output logic              cfgWrite,
  output logic [ADDR_W-1:0] cfgOffset,
  output logic [1:0]        cfgSize,
  output logic [31:0]       cfgWdata,
  input  logic [31:0]       cfgRdData,
  input  logic              kick,
  output logic              irq,
  output logic              notifyValid,
  output logic [15:0]       notifyIdx,
  output logic [31:0]       winSize
);

  localparam int unsigned WIN = nextPow2(HDR_END + CFG_SIZE);

  hdrCmd_t cmd;

  vio_hdr_ctrl #(
    .ADDR_W  (ADDR_W),
    .CFG_SIZE(CFG_SIZE)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqSize  (reqSize),
    .cmd      (cmd),
    .cfgValid (cfgValid),
    .cfgWrite (cfgWrite),
    .cfgOffset(cfgOffset)
  );

  vio_hdr_dp #(
    .NUM_QUEUES  (NUM_QUEUES),
    .QUEUE_DEPTH (QUEUE_DEPTH),
    .DEV_FEATURES(DEV_FEATURES)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .cmd        (cmd),
    .wdata      (reqWdata),
    .cfgRdData  (cfgRdData),
    .kick       (kick),
    .rspValid   (rspValid),
    .rspData    (rspData),
    .rspErr     (rspErr),
    .rspWarn    (rspWarn),
    .notifyValid(notifyValid),
    .notifyIdx  (notifyIdx),
    .irq        (irq)
  );

  assign cfgSize  = reqSize;
  assign cfgWdata = reqWdata;
  assign winSize  = WIN;

  // R13: one response exactly one cycle after each request
  p_rsp_follows_req_r13: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  p_no_stray_rsp_r13: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

endmodule

// File: tb/vio_hdr_port_test.sv
module vio_hdr_port_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid, rspErr, rspWarn;
  logic [31:0] rspData;
  logic        cfgValid, cfgWrite;
  logic [7:0]  cfgOffset;
  logic [1:0]  cfgSize;
  logic [31:0] cfgWdata, cfgRdData;
  logic        kick = 1'b0;
  logic        irq, notifyValid;
  logic [15:0] notifyIdx;
  logic [31:0] winSize;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [31:0] d;
    logic        e;
    logic        w;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  logic        lastCfgValid, lastCfgWrite;
  logic [7:0]  lastCfgOffset;
  logic        lastNotifyValid;
  logic [15:0] lastNotifyIdx;

  always #5 clk = ~clk;

  assign cfgRdData = 32'hA500_0000 | 32'(cfgOffset);

  vio_hdr_port #(
    .ADDR_W(8), .NUM_QUEUES(3), .QUEUE_DEPTH(128),
    .CFG_SIZE(13), .DEV_FEATURES(32'h1234_5678)
  ) uut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one access, expectation pushed to the scoreboard
  task automatic acc(bit wr, logic [7:0] a, logic [1:0] sz, logic [31:0] wd,
                     logic [31:0] ed, bit ee, bit ew, string tag);
    exp_t x;
    x.d = ed; x.e = ee; x.w = ew; x.tag = tag;
    expQ.push_back(x);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqSize = sz; reqWdata = wd;
    #1;
    lastCfgValid  = cfgValid;
    lastCfgWrite  = cfgWrite;
    lastCfgOffset = cfgOffset;
    @(negedge clk);
    reqValid = 1'b0;
    lastNotifyValid = notifyValid;
    lastNotifyIdx   = notifyIdx;
  endtask

  task automatic rd(logic [7:0] a, logic [1:0] sz, logic [31:0] ed, string tag);
    acc(1'b0, a, sz, 32'h0, ed, 1'b0, 1'b0, tag);
  endtask

  task automatic wr(logic [7:0] a, logic [1:0] sz, logic [31:0] wd, string tag);
    acc(1'b1, a, sz, wd, 32'h0, 1'b0, 1'b0, tag);
  endtask

  // monitor: pop and compare every response
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && rspValid) begin
        if (expQ.size() == 0) begin
          chk("R13 stray response", 32'd1, 32'd0);
        end else begin
          exp_t x;
          x = expQ.pop_front();
          chk({x.tag, " data"}, rspData, x.d);
          chk({x.tag, " err"},  32'(rspErr), 32'(x.e));
          chk({x.tag, " warn"}, 32'(rspWarn), 32'(x.w));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", 32'(irq), 0);
    chk("R1 rspValid", 32'(rspValid), 0);
    chk("R1 notifyValid", 32'(notifyValid), 0);
    rd(8'h04, 2'd2, 32'h0, "R1 guest");
    rd(8'h12, 2'd0, 32'h0, "R1 status");
    // R11 window
    chk("R11 winSize", winSize, 32'd64);
    // R2 device features
    rd(8'h00, 2'd2, 32'h1234_5678, "R2 devfeat");
    // R3 guest features and selector
    wr(8'h04, 2'd2, 32'hDEAD_BEEF, "R3 wr guest");
    rd(8'h04, 2'd2, 32'hDEAD_BEEF, "R3 guest");
    wr(8'h0E, 2'd1, 32'h1, "R3 wr qsel");
    rd(8'h0E, 2'd1, 32'h1, "R3 qsel");
    // R4 per-queue ring address and size
    wr(8'h08, 2'd2, 32'h1000_0001, "R4 wr qaddr1");
    wr(8'h0E, 2'd1, 32'h2, "R4 sel2");
    wr(8'h08, 2'd2, 32'h0000_2222, "R4 wr qaddr2");
    wr(8'h0E, 2'd1, 32'h1, "R4 sel1");
    rd(8'h08, 2'd2, 32'h1000_0001, "R4 qaddr1");
    rd(8'h0C, 2'd1, 32'd128, "R4 qsize");
    wr(8'h0E, 2'd1, 32'h5, "R4 sel5");
    wr(8'h08, 2'd2, 32'h55, "R4 wr qaddr5");
    rd(8'h08, 2'd2, 32'h0, "R4 qaddr5");
    rd(8'h0C, 2'd1, 32'h0, "R4 qsize5");
    wr(8'h0E, 2'd1, 32'h2, "R4 sel2b");
    rd(8'h08, 2'd2, 32'h0000_2222, "R4 qaddr2");
    // R5 notify
    wr(8'h10, 2'd1, 32'h0007, "R5 wr notify");
    chk("R5 notifyValid", 32'(lastNotifyValid), 1);
    chk("R5 notifyIdx", 32'(lastNotifyIdx), 32'h7);
    @(negedge clk);
    chk("R5 pulse ends", 32'(notifyValid), 0);
    rd(8'h10, 2'd1, 32'h7, "R5 notify rb");
    // R6/R7 interrupt
    rd(8'h13, 2'd0, 32'h0, "R7 isr idle");
    kick = 1'b1; @(negedge clk); kick = 1'b0;
    chk("R6 irq", 32'(irq), 1);
    rd(8'h13, 2'd0, 32'h1, "R7 isr set");
    chk("R7 irq cleared", 32'(irq), 0);
    rd(8'h13, 2'd0, 32'h0, "R7 isr again");
    kick = 1'b1;
    rd(8'h13, 2'd0, 32'h0, "R7 kick race");
    kick = 1'b0;
    chk("R7 kick wins", 32'(irq), 1);
    // R8 ignored writes (pending still set)
    acc(1'b1, 8'h00, 2'd2, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b1, "R8 wr devfeat");
    rd(8'h00, 2'd2, 32'h1234_5678, "R8 devfeat kept");
    acc(1'b1, 8'h13, 2'd0, 32'h0, 32'h0, 1'b0, 1'b1, "R8 wr isr");
    chk("R8 irq kept", 32'(irq), 1);
    // R9 errors
    acc(1'b1, 8'h0C, 2'd1, 32'h9, 32'h0, 1'b1, 1'b0, "R9 wr qsize");
    rd(8'h0C, 2'd1, 32'd128, "R9 qsize kept");
    acc(1'b0, 8'h04, 2'd1, 32'h0, 32'h0, 1'b1, 1'b0, "R9 bad size rd");
    acc(1'b1, 8'h04, 2'd1, 32'h1, 32'h0, 1'b1, 1'b0, "R9 bad size wr");
    rd(8'h04, 2'd2, 32'hDEAD_BEEF, "R9 guest kept");
    acc(1'b0, 8'h01, 2'd0, 32'h0, 32'h0, 1'b1, 1'b0, "R9 unmapped");
    acc(1'b0, 8'h40, 2'd2, 32'h0, 32'h0, 1'b1, 1'b0, "R9 out of window");
    acc(1'b0, 8'h21, 2'd0, 32'h0, 32'h0, 1'b1, 1'b0, "R9 past cfg");
    chk("R9 no forward", 32'(lastCfgValid), 0);
    // R10 configuration forwarding
    rd(8'h16, 2'd1, 32'hA500_0002, "R10 cfg rd");
    chk("R10 cfgValid", 32'(lastCfgValid), 1);
    chk("R10 cfgOffset", 32'(lastCfgOffset), 32'h2);
    wr(8'h20, 2'd0, 32'h3C, "R10 cfg wr");
    chk("R10 cfgWrite", 32'(lastCfgWrite), 1);
    chk("R10 last offset", 32'(lastCfgOffset), 32'd12);
    rd(8'h04, 2'd2, 32'hDEAD_BEEF, "R10 header untouched");
    // R12 status and device reset (irq pending, qsel 2)
    wr(8'h12, 2'd0, 32'h07, "R12 wr status");
    rd(8'h12, 2'd0, 32'h07, "R12 status");
    wr(8'h12, 2'd0, 32'h00, "R12 reset");
    chk("R12 irq", 32'(irq), 0);
    rd(8'h04, 2'd2, 32'h0, "R12 guest");
    rd(8'h0E, 2'd1, 32'h0, "R12 qsel");
    rd(8'h12, 2'd0, 32'h0, "R12 status0");
    rd(8'h08, 2'd2, 32'h0, "R12 qaddr0");
    @(negedge clk);
    // R13 every response accounted for
    chk("R13 queue drained", 32'(expQ.size()), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule